// File: doc/BRIEF.md
# Twelve-bit word byte packer

This block moves one sector's worth of data between a stream of 12-bit words and a stream of 8-bit bytes, in either direction. In packed mode two words share three bytes, with the middle byte split into two nibbles. In byte mode each word carries one byte in its low eight bits. A transfer starts with a single `start` pulse. The pulse carries the direction, the mode, a word count in negative two's-complement form and, for reads, the number of bytes the byte source actually holds.

On a write, the block takes words and always emits one full sector of bytes. Bytes past the data are zeros. `done` rises once the last byte of the sector has been accepted. On a read, it consumes exactly the transfer's byte count and emits the words. Bytes beyond the source length are not requested and count as zero. Both streams use valid/ready handshakes. Memory addressing and the medium itself are outside the block.

Top module: `word_byte_packer`

## Requirements
- R1: The number of words requested is 4096 minus `wc_neg` (12-bit), so `wc_neg` = 0 requests 4096 words before any cap is applied.
- R2: In packed mode a word at an even position w0 sets byte 3m to w0[7:0] and the low nibble of byte 3m+1 to w0[11:8].
- R3: In packed mode a word at an odd position w1 sets the high nibble of byte 3m+1 to w1[3:0] and byte 3m+2 to w1[11:4].
- R4: In packed mode a transfer of n words occupies (3n+1)/2 bytes, rounded down; with odd n the high nibble of the final data byte is zero.
- R5: In packed mode a request above 170 words moves only 170 words and has a 256-byte count; byte 255 carries no data.
- R6: In byte mode (`mode8` = 1) a write emits each word's bits 7:0 as one byte, and moves at most 256 words.
- R7: A write emits exactly 256 bytes, and every byte at or after the byte count is zero. `done` rises in the cycle after byte 255 is accepted, with `busy` low.
- R8: A packed read consumes exactly the byte count and rebuilds each word by the inverse of the R2/R3 placement, producing exactly the capped word count.
- R9: A byte-mode read produces one word per byte, with the byte in bits 7:0 and bits 11:8 zero.
- R10: On a read, bytes at index `src_len` and above are not requested (`bi_ready` stays low) and enter the words as zero.
- R11: After reset the block is idle with no valid or ready raised. `start` is taken only while `busy` is low, and `busy` is high from the next cycle. `done` is cleared by a taken `start` and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| dir_rd | input | 1 | 1 = bytes to words (read), 0 = words to bytes (write) |
| mode8 | input | 1 | 1 = one byte per word, 0 = two words in three bytes |
| wc_neg | input | 12 | Word count as a negative two's-complement value |
| src_len | input | 9 | Bytes held by the byte source on a read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished |
| wi_valid | input | 1 | Word input valid (write) |
| wi_ready | output | 1 | Word input accepted |
| wi_data | input | 12 | Word input data |
| bo_valid | output | 1 | Byte output valid (write) |
| bo_ready | input | 1 | Byte output accepted |
| bo_data | output | 8 | Byte output data |
| bi_valid | input | 1 | Byte input valid (read) |
| bi_ready | output | 1 | Byte input accepted |
| bi_data | input | 8 | Byte input data |
| wo_valid | output | 1 | Word output valid (read) |
| wo_ready | input | 1 | Word output accepted |
| wo_data | output | 12 | Word output data |

## Verification
The bench builds the block with its default 256-byte sector. With that size the 170-word packed cap, the 256-word byte-mode cap and the full 4096 request from a zero count can all be reached in a few hundred cycles per transfer. Pseudo-random backpressure on the byte and word outputs exercises the handshakes through whole sectors, including the padding run and the split nibble byte. A short source length on a read makes the zero-supplied bytes visible in the words.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  localparam int WORD_W = 12;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = WORD_W - BYTE_W;

  // requested words: 4096 - neg, where neg == 0 means 4096
  function automatic logic [WORD_W:0] wc_true(input logic [WORD_W-1:0] neg);
    return (WORD_W+1)'(1 << WORD_W) - {1'b0, neg};
  endfunction

  // packed-mode byte span of n words
  function automatic logic [WORD_W+1:0] bytes12(input logic [WORD_W:0] n);
    return (({1'b0, n} * (WORD_W+2)'(3)) + (WORD_W+2)'(1)) >> 1;
  endfunction
endpackage

// File: rtl/wbp_sizer.sv
module wbp_sizer
  import wbp_pkg::*;
#(
  parameter int SECT_BYTES = 256,
  parameter int BC_W       = $clog2(SECT_BYTES + 1)
) (
  input  logic [WORD_W-1:0] wc_neg,
  input  logic              mode8,
  output logic [BC_W-1:0]   n_words,
  output logic [BC_W-1:0]   n_bytes
);
  localparam int CAP12 = (SECT_BYTES * 2) / 3;

  logic [WORD_W:0]   tw;
  logic [WORD_W+1:0] b12;

  always_comb begin
    tw  = wc_true(wc_neg);
    b12 = bytes12(tw);
    if (mode8) begin
      if (tw > (WORD_W+1)'(SECT_BYTES)) n_bytes = BC_W'(SECT_BYTES);
      else                              n_bytes = BC_W'(tw);
      n_words = n_bytes;
    end else if (b12 > (WORD_W+2)'(SECT_BYTES)) begin
      n_bytes = BC_W'(SECT_BYTES);
      n_words = BC_W'(CAP12);
    end else begin
      n_bytes = BC_W'(b12);
      n_words = BC_W'(tw);
    end
  end
endmodule

// File: rtl/wbp_pack.sv
module wbp_pack
  import wbp_pkg::*;
#(
  parameter int SECT_BYTES = 256,
  parameter int BC_W       = $clog2(SECT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              mode8,
  input  logic [BC_W-1:0]   n_words,
  input  logic [BC_W-1:0]   n_bytes,
  input  logic              wi_valid,
  output logic              wi_ready,
  input  logic [WORD_W-1:0] wi_data,
  output logic              bo_valid,
  input  logic              bo_ready,
  output logic [BYTE_W-1:0] bo_data,
  output logic              active,
  output logic              fin,
  output logic              pad
);
  logic [BC_W-1:0]   k, wi;
  logic [1:0]        ph;
  logic [NIB_W-1:0]  nib;
  logic [BYTE_W-1:0] hi;
  logic              need_word, fire;
  logic [BYTE_W-1:0] raw;

  assign need_word = active && (wi < n_words) && (mode8 || ph != 2'd2);
  assign pad       = active && (k >= n_bytes);
  assign bo_valid  = active && (!need_word || wi_valid);
  assign wi_ready  = need_word && bo_ready;
  assign fire      = bo_valid && bo_ready;
  assign fin       = fire && (k == BC_W'(SECT_BYTES - 1));

  always_comb begin
    raw = '0;
    if (mode8 || ph == 2'd0)
      raw = need_word ? wi_data[BYTE_W-1:0] : '0;
    else if (ph == 2'd1)
      raw = {need_word ? wi_data[NIB_W-1:0] : {NIB_W{1'b0}}, nib};
    else
      raw = hi;
    bo_data = pad ? '0 : raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      k      <= '0;
      wi     <= '0;
      ph     <= '0;
      nib    <= '0;
      hi     <= '0;
    end else if (go) begin
      active <= 1'b1;
      k      <= '0;
      wi     <= '0;
      ph     <= '0;
    end else if (fire) begin
      k  <= k + 1'b1;
      ph <= (mode8 || ph == 2'd2) ? 2'd0 : ph + 2'd1;
      if (need_word) begin
        wi <= wi + 1'b1;
        if (!mode8 && ph == 2'd0) nib <= wi_data[WORD_W-1:BYTE_W];
        if (!mode8 && ph == 2'd1) hi  <= wi_data[WORD_W-1:NIB_W];
      end
      if (fin) active <= 1'b0;
    end
  end
endmodule

// File: rtl/wbp_unpack.sv
module wbp_unpack
  import wbp_pkg::*;
#(
  parameter int SECT_BYTES = 256,
  parameter int BC_W       = $clog2(SECT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              mode8,
  input  logic [BC_W-1:0]   n_bytes,
  input  logic [BC_W-1:0]   src_len,
  input  logic              bi_valid,
  output logic              bi_ready,
  input  logic [BYTE_W-1:0] bi_data,
  output logic              wo_valid,
  input  logic              wo_ready,
  output logic [WORD_W-1:0] wo_data,
  output logic              active,
  output logic              fin,
  output logic              fill
);
  logic [BC_W-1:0]   k;
  logic [1:0]        ph;
  logic [BYTE_W-1:0] lo;
  logic [NIB_W-1:0]  nib;
  logic [BYTE_W-1:0] cur;
  logic              avail, emits, fire;

  assign fill     = active && (k >= src_len);
  assign cur      = fill ? '0 : bi_data;
  assign avail    = fill || bi_valid;
  assign emits    = mode8 || ph != 2'd0;
  assign wo_valid = active && avail && emits;
  assign fire     = active && avail && (!emits || wo_ready);
  assign bi_ready = active && !fill && (!emits || wo_ready);
  assign fin      = fire && (k == n_bytes - 1'b1);

  always_comb begin
    if (mode8)           wo_data = {{NIB_W{1'b0}}, cur};
    else if (ph == 2'd1) wo_data = {cur[NIB_W-1:0], lo};
    else                 wo_data = {cur, nib};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      k      <= '0;
      ph     <= '0;
      lo     <= '0;
      nib    <= '0;
    end else if (go) begin
      active <= 1'b1;
      k      <= '0;
      ph     <= '0;
    end else if (fire) begin
      k  <= k + 1'b1;
      ph <= (mode8 || ph == 2'd2) ? 2'd0 : ph + 2'd1;
      if (!mode8 && ph == 2'd0) lo  <= cur;
      if (!mode8 && ph == 2'd1) nib <= cur[BYTE_W-1:NIB_W];
      if (fin) active <= 1'b0;
    end
  end
endmodule

// File: rtl/word_byte_packer.sv
module word_byte_packer
  import wbp_pkg::*;
#(
  parameter int SECT_BYTES = 256,
  parameter int BC_W       = $clog2(SECT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_rd,
  input  logic              mode8,
  input  logic [11:0]       wc_neg,
  input  logic [8:0]        src_len,
  output logic              busy,
  output logic              done,
  input  logic              wi_valid,
  output logic              wi_ready,
  input  logic [11:0]       wi_data,
  output logic              bo_valid,
  input  logic              bo_ready,
  output logic [7:0]        bo_data,
  input  logic              bi_valid,
  output logic              bi_ready,
  input  logic [7:0]        bi_data,
  output logic              wo_valid,
  input  logic              wo_ready,
  output logic [11:0]       wo_data
);
  logic            launch;
  logic            cfg_m8, cfg_rd;
  logic [BC_W-1:0] cfg_words, cfg_bytes, cfg_src;
  logic [BC_W-1:0] sz_words, sz_bytes;
  logic            pk_active, pk_fin, pk_pad;
  logic            up_active, up_fin, up_fill;

  assign busy   = pk_active || up_active;
  assign launch = start && !busy;

  wbp_sizer #(.SECT_BYTES(SECT_BYTES), .BC_W(BC_W)) u_size (
    .wc_neg (wc_neg),
    .mode8  (mode8),
    .n_words(sz_words),
    .n_bytes(sz_bytes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_m8    <= 1'b0;
      cfg_rd    <= 1'b0;
      cfg_words <= '0;
      cfg_bytes <= '0;
      cfg_src   <= '0;
      done      <= 1'b0;
    end else begin
      if (launch) begin
        cfg_m8    <= mode8;
        cfg_rd    <= dir_rd;
        cfg_words <= sz_words;
        cfg_bytes <= sz_bytes;
        cfg_src   <= BC_W'(src_len);
        done      <= 1'b0;
      end else if (pk_fin || up_fin) begin
        done      <= 1'b1;
      end
    end
  end

  wbp_pack #(.SECT_BYTES(SECT_BYTES), .BC_W(BC_W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (launch && !dir_rd),
    .mode8   (cfg_m8),
    .n_words (cfg_words),
    .n_bytes (cfg_bytes),
    .wi_valid(wi_valid),
    .wi_ready(wi_ready),
    .wi_data (wi_data),
    .bo_valid(bo_valid),
    .bo_ready(bo_ready),
    .bo_data (bo_data),
    .active  (pk_active),
    .fin     (pk_fin),
    .pad     (pk_pad)
  );

  wbp_unpack #(.SECT_BYTES(SECT_BYTES), .BC_W(BC_W)) u_unpack (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (launch && dir_rd),
    .mode8   (cfg_m8),
    .n_bytes (cfg_bytes),
    .src_len (cfg_src),
    .bi_valid(bi_valid),
    .bi_ready(bi_ready),
    .bi_data (bi_data),
    .wo_valid(wo_valid),
    .wo_ready(wo_ready),
    .wo_data (wo_data),
    .active  (up_active),
    .fin     (up_fin),
    .fill    (up_fill)
  );
endmodule

// File: rtl/wbp_checks.sv
module wbp_checks #(
  parameter int SECT_BYTES = 256,
  parameter int BC_W       = $clog2(SECT_BYTES + 1)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        wi_valid,
  input logic        wi_ready,
  input logic        bo_valid,
  input logic        bo_ready,
  input logic [7:0]  bo_data,
  input logic        wo_valid,
  input logic [11:0] wo_data,
  input logic        bi_ready,
  input logic        pad,
  input logic        fill,
  input logic        cfg_m8,
  input logic        cfg_rd
);
  logic [BC_W:0] sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sent <= '0;
    else if (start && !busy)    sent <= '0;
    else if (bo_valid && bo_ready) sent <= sent + 1'b1;
  end

  p_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bo_valid && pad |-> bo_data == 8'h00);

  p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bo_valid && bo_ready |-> sent < (BC_W+1)'(SECT_BYTES));

  p_sector_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !cfg_rd |-> sent == (BC_W+1)'(SECT_BYTES));

  p_word_with_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wi_valid && wi_ready |-> bo_valid && bo_ready);

  p_fill_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill |-> !bi_ready);

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wo_valid && cfg_m8 |-> wo_data[11:8] == 4'h0);

  p_one_side_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bo_valid && wo_valid));

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_take_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done);
endmodule

bind word_byte_packer wbp_checks #(.SECT_BYTES(SECT_BYTES), .BC_W(BC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .wi_valid(wi_valid),
  .wi_ready(wi_ready),
  .bo_valid(bo_valid),
  .bo_ready(bo_ready),
  .bo_data (bo_data),
  .wo_valid(wo_valid),
  .wo_data (wo_data),
  .bi_ready(bi_ready),
  .pad     (pk_pad),
  .fill    (up_fill),
  .cfg_m8  (cfg_m8),
  .cfg_rd  (cfg_rd)
);

// File: tb/sim_word_byte_packer.sv
module sim_word_byte_packer;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, dir_rd, mode8;
  logic [11:0] wc_neg;
  logic [8:0]  src_len;
  logic        busy, done;
  logic        wi_ready, bo_valid, bi_ready, wo_valid;
  logic [7:0]  bo_data;
  logic [11:0] wo_data;
  logic        bo_ready, wo_ready;
  logic [11:0] wsrc [512];
  logic [7:0]  bsrc [512];
  int          widx, bidx, run_id, seen_id;
  logic        bp;
  logic [7:0]  lfsr;

  logic [7:0]  exp_b[$];
  string       exp_bt[$];
  logic [11:0] exp_w[$];
  string       exp_wt[$];
  int n_chk, n_err, s_chk, s_err;

  word_byte_packer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_rd(dir_rd), .mode8(mode8),
    .wc_neg(wc_neg), .src_len(src_len), .busy(busy), .done(done),
    .wi_valid(1'b1), .wi_ready(wi_ready), .wi_data(wsrc[widx[8:0]]),
    .bo_valid(bo_valid), .bo_ready(bo_ready), .bo_data(bo_data),
    .bi_valid(1'b1), .bi_ready(bi_ready), .bi_data(bsrc[bidx[8:0]]),
    .wo_valid(wo_valid), .wo_ready(wo_ready), .wo_data(wo_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as the design hands them over
  initial begin
    bit fb, fw, fwi, fbi;
    lfsr = 8'h5a; bo_ready = 1'b1; wo_ready = 1'b1;
    widx = 0; bidx = 0; seen_id = 0;
    s_chk = 0; s_err = 0;
    forever begin
      @(negedge clk);
      if (run_id != seen_id) begin seen_id = run_id; widx = 0; bidx = 0; end
      fb  = bo_valid && bo_ready;
      fw  = wo_valid && wo_ready;
      fwi = wi_ready;
      fbi = bi_ready;
      if (fb) begin
        s_chk++;
        if (exp_b.size() == 0) begin
          s_err++; $display("FAIL R7: actual extra byte %0h expected none", bo_data);
        end else begin
          logic [7:0] e; string t;
          e = exp_b.pop_front(); t = exp_bt.pop_front();
          if (bo_data !== e) begin
            s_err++; $display("FAIL %s: actual %0h expected %0h", t, bo_data, e);
          end
        end
      end
      if (fw) begin
        s_chk++;
        if (exp_w.size() == 0) begin
          s_err++; $display("FAIL R8: actual extra word %0h expected none", wo_data);
        end else begin
          logic [11:0] e; string t;
          e = exp_w.pop_front(); t = exp_wt.pop_front();
          if (wo_data !== e) begin
            s_err++; $display("FAIL %s: actual %0h expected %0h", t, wo_data, e);
          end
        end
      end
      @(posedge clk); #1;
      if (fwi) widx++;
      if (fbi) bidx++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      bo_ready = bp ? lfsr[0] : 1'b1;
      wo_ready = bp ? lfsr[2] : 1'b1;
    end
  end

  function automatic logic [7:0] src_byte(input int idx, input int slen);
    return (idx < slen) ? bsrc[idx] : 8'h00;
  endfunction

  // driver: computes expected stream as a flat little-endian bit string
  task automatic run_case(input bit rd, input bit m8, input logic [11:0] neg,
                          input int slen, input bit backp, input bit poke,
                          input string tag);
    int tw, cw, bc, cyc;
    tw = (neg == 0) ? 4096 : 4096 - int'(neg);
    if (m8) begin cw = (tw > 256) ? 256 : tw; bc = cw; end
    else begin
      bc = (3 * tw + 1) / 2;
      if (bc > 256) begin bc = 256; cw = 170; end else cw = tw;
    end
    if (!rd) begin
      for (int k = 0; k < 256; k++) begin
        logic [7:0] v; string t;
        v = 8'h00;
        if (m8) begin
          if (k < cw) v = wsrc[k][7:0];
        end else begin
          for (int j = 0; j < 8; j++) begin
            int b; b = 8 * k + j;
            if (b / 12 < cw) v[j] = wsrc[b / 12][b % 12];
          end
        end
        if (k >= bc) t = "R7";
        else if (tag != "") t = tag;
        else t = (k % 3 == 2) ? "R3" : "R2";
        exp_b.push_back(v); exp_bt.push_back(t);
      end
    end else begin
      for (int i = 0; i < cw; i++) begin
        logic [11:0] v;
        v = 12'h000;
        if (m8) v = {4'h0, src_byte(i, slen)};
        else begin
          for (int j = 0; j < 12; j++) begin
            int b; logic [7:0] sb;
            b = 12 * i + j; sb = src_byte(b / 8, slen);
            v[j] = sb[b % 8];
          end
        end
        exp_w.push_back(v); exp_wt.push_back(tag);
      end
    end
    @(posedge clk); #1;
    bp = backp; run_id++;
    dir_rd = rd; mode8 = m8; wc_neg = neg; src_len = 9'(slen); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(busy === 1'b1 && done === 1'b0, "R11", {busy, done}, 2'b10);
    cyc = 0;
    while (done !== 1'b1 && cyc < 3000) begin
      @(posedge clk); #1;
      cyc++;
      if (poke && cyc == 10) begin
        start = 1'b1; dir_rd = ~rd; mode8 = ~m8; wc_neg = 12'hfff;
      end else begin
        start = 1'b0; dir_rd = rd; mode8 = m8; wc_neg = neg;
      end
      @(negedge clk);
    end
    start = 1'b0;
    if (done !== 1'b1) begin
      chk(1'b0, {tag, " watchdog"}, cyc, 0);
      rst_n = 1'b0; #25; rst_n = 1'b1;
    end
    chk(done === 1'b1 && busy === 1'b0, rd ? "R8" : "R7", {done, busy}, 2'b10);
    chk(rd ? exp_w.size() == 0 : exp_b.size() == 0, tag == "" ? "R2" : tag,
        rd ? exp_w.size() : exp_b.size(), 0);
    if (!rd) chk(widx == cw, tag == "" ? "R1" : tag, widx, cw);
    else begin
      int nb; nb = (slen < bc) ? slen : bc;
      chk(bidx == nb, tag, bidx, nb);
    end
    exp_b.delete(); exp_bt.delete(); exp_w.delete(); exp_wt.delete();
    repeat (3) @(negedge clk);
    chk(done === 1'b1, "R11", done, 1);
  endtask

  initial begin
    n_chk = 0; n_err = 0; run_id = 0; bp = 1'b0;
    for (int i = 0; i < 512; i++) begin
      wsrc[i] = 12'((i * 397 + 12'h9a5) ^ (i << 5));
      bsrc[i] = 8'((i * 29 + 7) ^ (i << 3));
    end
    rst_n = 1'b0; start = 1'b0; dir_rd = 1'b0; mode8 = 1'b0;
    wc_neg = 12'h000; src_len = 9'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11: idle after reset
    chk(busy === 1'b0 && done === 1'b0, "R11", {busy, done}, 0);
    chk(bo_valid === 1'b0 && wo_valid === 1'b0 && wi_ready === 1'b0 && bi_ready === 1'b0,
        "R11", {bo_valid, wo_valid, wi_ready, bi_ready}, 0);

    run_case(1'b0, 1'b0, 12'(4096 - 4), 0, 1'b0, 1'b0, "");    // R2 R3 placement
    run_case(1'b0, 1'b0, 12'(4096 - 1), 0, 1'b0, 1'b0, "R4");  // odd count
    run_case(1'b0, 1'b0, 12'(4096 - 7), 0, 1'b1, 1'b0, "R4");
    run_case(1'b0, 1'b0, 12'h000, 0, 1'b1, 1'b0, "R5");        // R1 4096 capped to 170
    run_case(1'b0, 1'b1, 12'(4096 - 5), 0, 1'b1, 1'b0, "R6");
    run_case(1'b0, 1'b1, 12'h000, 0, 1'b0, 1'b0, "R1");        // byte mode cap 256
    run_case(1'b1, 1'b0, 12'(4096 - 4), 256, 1'b1, 1'b0, "R8");
    run_case(1'b1, 1'b0, 12'(4096 - 3), 2, 1'b0, 1'b0, "R10");
    run_case(1'b1, 1'b1, 12'(4096 - 3), 256, 1'b1, 1'b0, "R9");
    run_case(1'b1, 1'b0, 12'h000, 256, 1'b1, 1'b0, "R5");
    run_case(1'b0, 1'b0, 12'(4096 - 6), 0, 1'b1, 1'b1, "R11"); // start while busy

    repeat (2) @(negedge clk);
    n_chk += s_chk; n_err += s_err;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule